// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the two long memory sequences around an interrupt in a small 8-bit core. When an instruction has finished and an unmasked request is waiting, it saves the core's register context on a stack that grows toward lower addresses. It then sets the mask bits in the condition code byte and reads a two-byte service address. When the core signals a return instruction, it reads the saved context back in the opposite order and hands the restored values to the core.

The core shares one byte-wide memory port with the block. A write stores the byte at the current stack pointer and then lowers the pointer by one. A read first raises the pointer by one and then fetches. The maskable request can be taken on a falling edge or on a low level, chosen by a configuration input. The non-maskable request is always level sensitive.

The block keeps its own copy of the context bytes and the stack pointer while it works. When a sequence ends, the core takes the new values from the output ports, in the cycle where the matching done strobe is high.

Top module: `intr_seq`

## Requirements
- R1: After reset, busy, both done strobes, the memory write enable and the read enable are all low, and sp_out is 0x0000.
- R2: An accepted request produces nine writes in consecutive cycles. The first goes to sp_in and each later one is one address lower. The bytes are, in order: PC[7:0], PC[15:8], IY[7:0], IY[15:8], IX[7:0], IX[15:8], A, B, CCR. When entry completes, sp_out equals sp_in minus 9.
- R3: The CCR byte written to the stack is the value held before entry. The entry result in ccr_out has bit 4 (the maskable mask) set. For a non-maskable entry, bit 6 (the non-maskable mask) is also set.
- R4: After the ninth write, two reads fetch the service address. The high byte comes from the even vector address and the low byte from the next address. The vector is 0xFFF2 for the maskable request and 0xFFF4 for the non-maskable one. pc_out then holds the assembled address, and entry_done is high for exactly one cycle.
- R5: A return request produces nine reads at ascending addresses from sp_in+1. They restore CCR, B, A, IX high, IX low, IY high, IY low, PC high and PC low, in that order. sp_out ends at sp_in plus 9, and ret_done pulses for one cycle.
- R6: On return, ccr_out bit 6 equals the pulled bit 6 AND the bit 6 of ccr_in when the return began. A return can clear that bit but never set it.
- R7: In edge mode (irq_edge=1), a falling edge on irq_n is remembered while CCR bit 4 is set. It is serviced once bit 4 clears, and it is serviced only once.
- R8: In level mode (irq_edge=0), the maskable request is seen only while irq_n is low. A request released before the mask clears is lost. A request still held low is taken again as soon as a return clears the mask.
- R9: A low nmi_n is not taken while ccr_in bit 6 is set. The maskable request is still served in that case.
- R10: When both requests are pending and unmasked, the non-maskable one is served.
- R11: A sequence starts only in a cycle where the block is idle, neither done strobe is high, and insn_boundary (for entry) or rti_req (for return) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Maskable request, active low |
| nmi_n | input | 1 | Non-maskable request, active low |
| irq_edge | input | 1 | 1: falling-edge trigger for irq_n, 0: low-level trigger |
| insn_boundary | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Start the return sequence |
| sp_in | input | 16 | Core stack pointer at sequence start |
| pc_in | input | 16 | Core program counter (return address) |
| iy_in | input | 16 | Core index register Y |
| ix_in | input | 16 | Core index register X |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code byte; bit 4 maskable mask, bit 6 non-maskable mask |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data is returned in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | A sequence is in progress |
| entry_done | output | 1 | One-cycle strobe: entry finished, outputs valid |
| ret_done | output | 1 | One-cycle strobe: return finished, outputs valid |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Service address after entry, restored PC after return |
| iy_out | output | 16 | Restored IY |
| ix_out | output | 16 | Restored IX |
| a_out | output | 8 | Restored A |
| b_out | output | 8 | Restored B |
| ccr_out | output | 8 | Masked CCR after entry, restored CCR after return |

## Verification
The assertions check the properties that hold in every cycle:
- Reads and writes never occur together.
- Back-to-back writes step down by one address, and back-to-back reads step up by one.
- Every entry result carries the maskable mask.
- No return sets the non-maskable mask where it was clear.
- A sequence begins only after a boundary or return request.
- The done strobe lasts a single cycle.

Only the bench scenarios can show the rest:
- The exact bytes and their stack order.
- The vector chosen.
- The restored values.
- Edge latching across a masked interval, and the loss of a released level request.
- Re-entry of a held level request after return.
- Priority between the two requests.

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter logic [15:0] VEC_IRQ = 16'hFFF2,
  parameter logic [15:0] VEC_NMI = 16'hFFF4,
  parameter int I_BIT = 4,
  parameter int X_BIT = 6,
  parameter int FRAME = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        nmi_n,
  input  logic        irq_edge,
  input  logic        insn_boundary,
  input  logic        rti_req,
  input  logic [15:0] sp_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] iy_in,
  input  logic [15:0] ix_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  ccr_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        entry_done,
  output logic        ret_done,
  output logic [15:0] sp_out,
  output logic [15:0] pc_out,
  output logic [15:0] iy_out,
  output logic [15:0] ix_out,
  output logic [7:0]  a_out,
  output logic [7:0]  b_out,
  output logic [7:0]  ccr_out
);
  localparam int CW = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_VEC, S_PULL} st_t;
  st_t st;

  logic [7:0]    ctx [FRAME];
  logic [15:0]   sp;
  logic [CW-1:0] cnt;
  logic          nmi_sel, xkeep, irq_prev, irq_latch;

  wire irq_fall = irq_prev & ~irq_n;
  wire irq_pend = irq_edge ? irq_latch : ~irq_n;
  wire nmi_go   = ~nmi_n & ~ccr_in[X_BIT];
  wire irq_go   = irq_pend & ~ccr_in[I_BIT];
  wire idle_ok  = (st == S_IDLE) && !entry_done && !ret_done;
  wire ret_go   = idle_ok && rti_req;
  wire take     = idle_ok && !rti_req && insn_boundary && (nmi_go || irq_go);
  wire [15:0] vec = nmi_sel ? VEC_NMI : VEC_IRQ;

  assign mem_we    = (st == S_PUSH);
  assign mem_re    = (st == S_VEC) || (st == S_PULL);
  assign mem_addr  = (st == S_PUSH) ? sp :
                     (st == S_PULL) ? sp + 16'd1 : vec + {15'd0, cnt[0]};
  assign mem_wdata = ctx[cnt];
  assign busy      = (st != S_IDLE);
  assign sp_out    = sp;
  assign pc_out    = {ctx[1], ctx[0]};
  assign iy_out    = {ctx[3], ctx[2]};
  assign ix_out    = {ctx[5], ctx[4]};
  assign a_out     = ctx[6];
  assign b_out     = ctx[7];
  assign ccr_out   = ctx[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sp <= '0;
      nmi_sel <= 1'b0;
      xkeep <= 1'b0;
      irq_prev <= 1'b1;
      irq_latch <= 1'b0;
      entry_done <= 1'b0;
      ret_done <= 1'b0;
      for (int i = 0; i < FRAME; i++) ctx[i] <= '0;
    end else begin
      irq_prev <= irq_n;
      entry_done <= 1'b0;
      ret_done <= 1'b0;
      irq_latch <= irq_edge && (irq_latch || irq_fall) && !(take && !nmi_go);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (ret_go) begin
            sp <= sp_in;
            xkeep <= ccr_in[X_BIT];
            st <= S_PULL;
          end else if (take) begin
            ctx[0] <= pc_in[7:0];
            ctx[1] <= pc_in[15:8];
            ctx[2] <= iy_in[7:0];
            ctx[3] <= iy_in[15:8];
            ctx[4] <= ix_in[7:0];
            ctx[5] <= ix_in[15:8];
            ctx[6] <= a_in;
            ctx[7] <= b_in;
            ctx[8] <= ccr_in;
            sp <= sp_in;
            nmi_sel <= nmi_go;
            st <= S_PUSH;
          end
        end
        S_PUSH: begin
          sp <= sp - 16'd1;
          if (cnt == LAST) begin
            cnt <= '0;
            ctx[8][I_BIT] <= 1'b1;
            if (nmi_sel) ctx[8][X_BIT] <= 1'b1;
            st <= S_VEC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_VEC: begin
          if (cnt == '0) begin
            ctx[1] <= mem_rdata;
            cnt <= cnt + 1'b1;
          end else begin
            ctx[0] <= mem_rdata;
            cnt <= '0;
            entry_done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_PULL: begin
          sp <= sp + 16'd1;
          if (cnt == '0) begin
            ctx[8] <= mem_rdata;
            ctx[8][X_BIT] <= mem_rdata[X_BIT] & xkeep;
          end else begin
            ctx[LAST - cnt] <= mem_rdata;
          end
          if (cnt == LAST) begin
            cnt <= '0;
            ret_done <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic        busy,
  input logic        entry_done,
  input logic        ret_done,
  input logic        insn_boundary,
  input logic        rti_req,
  input logic [7:0]  ccr_out,
  input logic        xkeep
);
  p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_push_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - 16'd1);

  p_read_asc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) + 16'd1);

  p_entry_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> ccr_out[4]);

  p_x_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> !(ccr_out[6] && !xkeep));

  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(insn_boundary) || $past(rti_req)));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);
endmodule

bind intr_seq intr_seq_chk u_chk (.*);

// File: tb/tb_intr_seq.sv
`timescale 1ns/100ps
module tb_intr_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, irq_n, nmi_n, irq_edge, insn_boundary, rti_req;
  logic [15:0] sp_in, pc_in, iy_in, ix_in;
  logic [7:0]  a_in, b_in, ccr_in;
  logic [15:0] mem_addr, sp_out, pc_out, iy_out, ix_out;
  logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, ccr_out;
  logic mem_we, mem_re, busy, entry_done, ret_done;

  intr_seq dut (.*);

  logic [7:0] mem [256];
  logic       tb_we;
  logic [7:0] tb_a, tb_d;
  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_we && mem_addr[15:8] == 8'h00) mem[mem_addr[7:0]] <= mem_wdata;
  end
  always_comb begin
    case (mem_addr)
      16'hFFF2: mem_rdata = 8'h12;
      16'hFFF3: mem_rdata = 8'h34;
      16'hFFF4: mem_rdata = 8'h56;
      16'hFFF5: mem_rdata = 8'h78;
      default:  mem_rdata = mem[mem_addr[7:0]];
    endcase
  end

  typedef struct packed {
    logic        nmi;
    logic [15:0] sp, pc, iy, ix;
    logic [7:0]  a, b, ccr;
  } row_t;

  localparam row_t TBL [4] = '{
    '{1'b0, 16'h00F0, 16'h1A2B, 16'h3C4D, 16'h5E6F, 8'h71, 8'h82, 8'h00},
    '{1'b1, 16'h00C8, 16'hFFFF, 16'h0001, 16'h8000, 8'h00, 8'hFF, 8'h0F},
    '{1'b0, 16'h0080, 16'h0000, 16'hAAAA, 16'h5555, 8'h5A, 8'hA5, 8'h2A},
    '{1'b1, 16'h0009, 16'h4321, 16'h1357, 16'h2468, 8'h99, 8'h66, 8'hA1}
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done(input bit ret, input string req);
    bit seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      seen = ret ? ret_done : entry_done;
    end
    check(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic pulse_boundary();
    @(negedge clk) insn_boundary = 1'b1;
    @(negedge clk) insn_boundary = 1'b0;
  endtask

  task automatic do_return();
    sp_in = sp_out;
    ccr_in = ccr_out;
    @(negedge clk);
    rti_req = 1'b1;
    @(negedge clk) rti_req = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin tb_we = 1'b1; tb_a = a; tb_d = d; end
    @(negedge clk) tb_we = 1'b0;
  endtask

  function automatic logic [7:0] frame_byte(row_t r, int k);
    case (k)
      0: return r.pc[7:0];
      1: return r.pc[15:8];
      2: return r.iy[7:0];
      3: return r.iy[15:8];
      4: return r.ix[7:0];
      5: return r.ix[15:8];
      6: return r.a;
      7: return r.b;
      default: return r.ccr;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 0; irq_n = 1; nmi_n = 1; irq_edge = 0; insn_boundary = 0; rti_req = 0;
    sp_in = 0; pc_in = 0; iy_in = 0; ix_in = 0; a_in = 0; b_in = 0; ccr_in = 8'h50;
    tb_we = 0; tb_a = 0; tb_d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 strobes", {30'd0, entry_done, ret_done}, 0);
    check("R1 mem enables", {30'd0, mem_we, mem_re}, 0);
    check("R1 sp", {16'd0, sp_out}, 0);

    foreach (TBL[r]) begin
      row_t t = TBL[r];
      sp_in = t.sp; pc_in = t.pc; iy_in = t.iy; ix_in = t.ix;
      a_in = t.a; b_in = t.b; ccr_in = t.ccr; irq_edge = 0;
      if (t.nmi) nmi_n = 0; else irq_n = 0;
      pulse_boundary();
      nmi_n = 1; irq_n = 1;
      wait_done(0, "R4 entry done");
      for (int k = 0; k < 9; k++)
        check("R2 stacked byte", {24'd0, mem[8'(t.sp - 16'(k))]}, {24'd0, frame_byte(t, k)});
      check("R2 sp after entry", {16'd0, sp_out}, {16'd0, t.sp - 16'd9});
      check("R3 ccr after entry", {24'd0, ccr_out},
            {24'd0, t.ccr | 8'h10 | (t.nmi ? 8'h40 : 8'h00)});
      check("R4 vector", {16'd0, pc_out}, t.nmi ? 32'h5678 : 32'h1234);
      @(negedge clk);
      check("R4 strobe one cycle", {31'd0, entry_done}, 0);
      do_return();
      wait_done(1, "R5 return done");
      check("R5 pc", {16'd0, pc_out}, {16'd0, t.pc});
      check("R5 iy", {16'd0, iy_out}, {16'd0, t.iy});
      check("R5 ix", {16'd0, ix_out}, {16'd0, t.ix});
      check("R5 a b", {16'd0, a_out, b_out}, {16'd0, t.a, t.b});
      check("R6 ccr restored", {24'd0, ccr_out}, {24'd0, t.ccr});
      check("R5 sp after return", {16'd0, sp_out}, {16'd0, t.sp});
      @(negedge clk);
    end

    // R6: a return cannot set the non-maskable mask
    poke(8'h41, 8'h5F); poke(8'h42, 8'h11); poke(8'h43, 8'h22);
    poke(8'h44, 8'h33); poke(8'h45, 8'h44); poke(8'h46, 8'h55);
    poke(8'h47, 8'h66); poke(8'h48, 8'h77); poke(8'h49, 8'h88);
    sp_in = 16'h0040; ccr_in = 8'h00;
    @(negedge clk) rti_req = 1'b1;
    @(negedge clk) rti_req = 1'b0;
    wait_done(1, "R6 return done");
    check("R6 X not set by return", {24'd0, ccr_out}, 32'h1F);
    check("R5 frame pc", {16'd0, pc_out}, 32'h7788);
    check("R5 frame ix", {16'd0, ix_out}, 32'h3344);

    // R7: edge latched while masked, served once
    repeat (2) @(negedge clk);
    sp_in = 16'h00F0; irq_edge = 1; ccr_in = 8'h10;
    @(negedge clk) irq_n = 0;
    @(negedge clk) irq_n = 1;
    insn_boundary = 1;
    repeat (5) @(negedge clk);
    insn_boundary = 0;
    check("R7 masked edge waits", {31'd0, busy}, 0);
    ccr_in = 8'h00;
    pulse_boundary();
    check("R7 edge served after unmask", {31'd0, busy}, 1);
    wait_done(0, "R7 entry done");
    check("R7 irq vector", {16'd0, pc_out}, 32'h1234);
    repeat (2) @(negedge clk);
    pulse_boundary();
    check("R7 edge served once", {31'd0, busy}, 0);

    // R8: level mode, released request is lost
    irq_edge = 0; ccr_in = 8'h10;
    @(negedge clk) irq_n = 0;
    repeat (3) @(negedge clk);
    irq_n = 1; ccr_in = 8'h00;
    pulse_boundary();
    check("R8 released level lost", {31'd0, busy}, 0);
    // R8: held level retaken after return clears mask
    irq_n = 0;
    pulse_boundary();
    wait_done(0, "R8 entry done");
    @(negedge clk);
    do_return();
    wait_done(1, "R8 return done");
    ccr_in = ccr_out;
    check("R8 mask cleared by return", {31'd0, ccr_out[4]}, 0);
    pulse_boundary();
    check("R8 held level retaken", {31'd0, busy}, 1);
    irq_n = 1;
    wait_done(0, "R8 second entry done");

    // R11: no start without boundary
    repeat (2) @(negedge clk);
    ccr_in = 8'h00; irq_n = 0;
    repeat (8) @(negedge clk);
    check("R11 no boundary no start", {31'd0, busy}, 0);
    irq_n = 1;

    // R9: non-maskable blocked by X, maskable still served
    ccr_in = 8'h50; nmi_n = 0;
    insn_boundary = 1;
    repeat (4) @(negedge clk);
    insn_boundary = 0;
    check("R9 nmi blocked by X", {31'd0, busy}, 0);
    ccr_in = 8'h40; irq_n = 0;
    pulse_boundary();
    irq_n = 1;
    wait_done(0, "R9 entry done");
    check("R9 irq served while X set", {16'd0, pc_out}, 32'h1234);

    // R10: priority
    repeat (2) @(negedge clk);
    ccr_in = 8'h00; irq_n = 0; nmi_n = 0;
    pulse_boundary();
    irq_n = 1; nmi_n = 1;
    wait_done(0, "R10 entry done");
    check("R10 nmi vector wins", {16'd0, pc_out}, 32'h5678);
    check("R10 X set", {31'd0, ccr_out[6]}, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule